// File: doc/BRIEF.md
# Information Block Key Sequence Unlocker

This block guards access to the system and user information area of a flash controller. It is a write-only key register. Software opens the area by writing three fixed 32-bit key words to it, in a fixed order. After the third correct word, the block raises `info_access_en`. The next write to the key register closes the area again, whatever value is written.

The key register decodes at byte offset 0x40 of the controller register space. Writes to any other offset, and cycles with the write strobe low, leave the sequencer untouched. A read of the key register always returns zero.

The sequencer has four states:

- `ST_LOCKED`: start state, area closed.
- `ST_KEY1_OK`: first key word seen.
- `ST_KEY2_OK`: first two key words seen.
- `ST_OPEN`: area open.

Its transitions, for each write that hits the key register:

- `T_ADVANCE`: the expected next key word moves one state forward. LOCKED goes to KEY1_OK, KEY1_OK to KEY2_OK, KEY2_OK to OPEN.
- `T_RESTART`: the first key word arriving in KEY1_OK or KEY2_OK goes to KEY1_OK.
- `T_ABORT`: any other wrong word goes to LOCKED.
- `T_RELOCK`: any write in OPEN goes to LOCKED.
- `T_HOLD`: a cycle with no hit keeps the state.

Top module: `info_key_unlock`

## Requirements
- R1: After reset, the sequencer is in its locked start state and `info_access_en` is 0.
- R2: Writing the key words 0x3A7F5CA3, 0xA1E34F20 and 0x9608B2C1, in that order, to offset 0x40 sets `info_access_en` to 1. It rises on the clock edge that takes the third write, and not earlier.
- R3: Any write at offset 0x40 whose value is not the expected next key word aborts the sequence and sends it back to the start state, with `info_access_en` staying 0. The one exception is covered by R4.
- R4: A wrong word that equals the first key word (0x3A7F5CA3) counts as step one of a new sequence. After it, the second and third key words alone open access.
- R5: While access is open, a write of any value to offset 0x40, including any key word, clears `info_access_en` on the clock edge that takes the write. The sequencer then restarts from the start state.
- R6: A cycle with `bus_wr` low, or with `bus_addr` different from 0x40, changes neither the sequencer state nor `info_access_en`.
- R7: `bus_rdata` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the key register, always zero |
| info_access_en | output | 1 | Information area access enable |

## Verification
The bench sweeps all 64 ordered triples built from the three key words and one wrong word. Any misrouted transition shows up there, for example a design that opens on an out-of-order set of keys or that skips a step.

It drives restart sequences that repeat the first key word. A design that treats that word as an abort would stay locked on them.

While access is open, it writes key words and ordinary words. A design that re-enters step one on a relock, or ignores a relocking key word, would stay open or open too early.

It interleaves writes to other offsets and idle strobes with addresses that match. A design that decodes only the address or only the strobe would advance or abort wrongly.

// File: rtl/info_key_pkg.sv
package info_key_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int KEY_COUNT = 3;

    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_KEY1_OK = 2'd1,
        ST_KEY2_OK = 2'd2,
        ST_OPEN    = 2'd3
    } seq_state_t;

    function automatic logic [WORD_W-1:0] key_word(input int idx);
        case (idx)
            0:       return 32'h3A7F_5CA3;
            1:       return 32'hA1E3_4F20;
            default: return 32'h9608_B2C1;
        endcase
    endfunction
endpackage

// File: rtl/info_key_match.sv
module info_key_match
    import info_key_pkg::*;
(
    input  logic [WORD_W-1:0]    wdata,
    output logic [KEY_COUNT-1:0] is_key
);
    for (genvar g = 0; g < KEY_COUNT; g++) begin : g_cmp
        assign is_key[g] = (wdata == key_word(g));
    end
endmodule

// File: rtl/info_key_seq_fsm.sv
module info_key_seq_fsm
    import info_key_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [KEY_COUNT-1:0] is_key,
    output logic                 access_en
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (hit) begin
            unique case (state_q)
                ST_LOCKED:  state_d = is_key[0] ? ST_KEY1_OK : ST_LOCKED;
                ST_KEY1_OK: state_d = is_key[1] ? ST_KEY2_OK :
                                      (is_key[0] ? ST_KEY1_OK : ST_LOCKED);
                ST_KEY2_OK: state_d = is_key[2] ? ST_OPEN :
                                      (is_key[0] ? ST_KEY1_OK : ST_LOCKED);
                ST_OPEN:    state_d = ST_LOCKED;
                default:    state_d = ST_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        access_en = (state_q == ST_OPEN);
    end

    // R2: access only opens after the third key word arrives in step two
    assert_open_after_third_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> $past(hit && is_key[2] && state_q == ST_KEY2_OK));

    // R3: a non-key word in step one aborts to the start state
    assert_abort_step1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY1_OK && hit && !is_key[1] && !is_key[0]) |=> state_q == ST_LOCKED);

    // R5: any write while open closes access
    assert_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && hit) |=> (!access_en && state_q == ST_LOCKED));

    // R6: no hit, no change
    assert_hold_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(state_q));
endmodule

// File: rtl/info_key_unlock.sv
module info_key_unlock
    import info_key_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY_OFFSET = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              info_access_en
);
    logic                 hit;
    logic [KEY_COUNT-1:0] is_key;

    assign hit       = bus_wr && (bus_addr == KEY_OFFSET);
    assign bus_rdata = '0;

    info_key_match u_match (
        .wdata  (bus_wdata),
        .is_key (is_key)
    );

    info_key_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .is_key    (is_key),
        .access_en (info_access_en)
    );
endmodule

// File: tb/info_key_unlock_bench.sv
`timescale 1ns/1ps
module info_key_unlock_bench;
    localparam logic [31:0] K0 = 32'h3A7F5CA3;
    localparam logic [31:0] K1 = 32'hA1E34F20;
    localparam logic [31:0] K2 = 32'h9608B2C1;
    localparam logic [31:0] KX = 32'h1234_5678;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        info_access_en;

    int checks = 0, fails = 0, mstate = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    info_key_unlock u_info_key_unlock (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .info_access_en(info_access_en)
    );

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: return K0;
            1: return K1;
            2: return K2;
            default: return KX;
        endcase
    endfunction

    // expected step count (0..3) after a write to the key offset
    function automatic int model(input int s, input logic [31:0] d);
        if (s == 3) return 0;
        if (d == pick(s)) return s + 1;
        if (d == K0) return 1;
        return 0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s access actual %0b expected %0b", req, act, exp);
        end
        checks++;
        if (bus_rdata !== 32'h0) begin
            fails++;
            $display("FAIL R7 rdata actual %h expected 0", bus_rdata);
        end
    endtask

    task automatic wr(input logic en, input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_wr = en; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        if (en && a == 8'h40) mstate = model(mstate, d);
        check(req, info_access_en, mstate == 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", info_access_en, 1'b0);

        // R2 / R3 sweep over all ordered triples
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++) begin
                    wr(1, 8'h40, pick(a), "R3");
                    wr(1, 8'h40, pick(b), "R3");
                    wr(1, 8'h40, pick(c), (a == 0 && b == 1 && c == 2) ? "R2" : "R3");
                    // bring back to start: a non-key word, plus one more if it just relocked
                    wr(1, 8'h40, KX, "R5");
                    if (mstate != 0) wr(1, 8'h40, KX, "R3");
                end

        // R4: restart on repeated first key
        wr(1, 8'h40, K0, "R4"); wr(1, 8'h40, K0, "R4");
        wr(1, 8'h40, K1, "R4"); wr(1, 8'h40, K2, "R4");
        wr(1, 8'h40, KX, "R5");
        wr(1, 8'h40, K0, "R4"); wr(1, 8'h40, K1, "R4");
        wr(1, 8'h40, K0, "R4"); wr(1, 8'h40, K1, "R4"); wr(1, 8'h40, K2, "R4");

        // R5: relock with a key word, then partial keys must not reopen
        wr(1, 8'h40, K0, "R5");
        wr(1, 8'h40, K1, "R5"); wr(1, 8'h40, K2, "R5");

        // R6: ignored cycles mid-sequence and while open
        wr(1, 8'h40, K0, "R6"); wr(1, 8'h44, KX, "R6"); wr(0, 8'h40, KX, "R6");
        wr(1, 8'h40, K1, "R6"); wr(1, 8'h3C, K0, "R6");
        wr(1, 8'h40, K2, "R6");
        wr(1, 8'h00, KX, "R6"); wr(0, 8'h40, K0, "R6");
        wr(1, 8'h40, 32'h0, "R5");

        // R1: reset while open
        wr(1, 8'h40, K0, "R2"); wr(1, 8'h40, K1, "R2"); wr(1, 8'h40, K2, "R2");
        rst_n = 0; @(negedge clk); rst_n = 1; mstate = 0;
        @(negedge clk);
        check("R1", info_access_en, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule